// File: doc/BRIEF.md
# Memory Controller Burst Master

This block sits on the user side of a DDR2 memory controller and drives its native request interface. A single-cycle `go` command picks the operation (write or read), the chip-select, row, bank and column of the first beat, the burst length and the byte lanes. The block holds the command until the controller reports that its initialisation is complete. It then issues the burst and returns a one-cycle `done` pulse when the burst has finished.

A write burst sends a generated data pattern on every beat. A read burst sends one request and then counts the returned beats. Each returned beat is compared against the same pattern on the enabled byte lanes only. The block therefore works as a write-then-read-back check engine. It obeys the controller's ready flag on every beat: while ready is low, everything it presents stays frozen.

Top module: `mc_burst_master`

## Requirements
- R1: While `mc_init_ok` is low, `mc_wr_req` and `mc_rd_req` stay low. A command given before then waits and is issued once `mc_init_ok` rises. Both requests are low after reset.
- R2: `mc_addr` equals the concatenation {chip-select, row, bank, column} of the command, chip-select in the MSBs and column in the LSBs. It is constant for the whole burst.
- R3: A write burst holds `mc_wr_req` high on every beat. A beat is accepted when request and `mc_ready` are both high. On beat k (from 0), byte lane j of `mc_wdata` is (A + NBYTE*k + j) mod 256, where A is the combined address and NBYTE = 2 by default. The beat index advances only on an accepted beat.
- R4: `mc_burst_start` is high for exactly one cycle per burst: the first cycle in which that burst's request is presented.
- R5: A cycle with a request high and `mc_ready` low is a stall. In the next cycle `mc_addr`, `mc_wdata`, `mc_be`, `mc_size`, `mc_wr_req` and `mc_rd_req` are unchanged.
- R6: `mc_size` carries the burst length in beats. A requested length of 0 becomes 1, and a length above MAX_SIZE (4 by default) becomes MAX_SIZE. A write burst has exactly that many accepted beats.
- R7: A read burst is one accepted `mc_rd_req` carrying the size. No further request is made until that many `mc_rvalid` beats have arrived.
- R8: `mc_wr_req` and `mc_rd_req` are never high in the same cycle.
- R9: `done` is high for one cycle. It comes in the cycle after the last accepted write beat, or after the last read beat is sampled.
- R10: When `done` pulses for a read, `mismatch` shows whether any returned byte on an enabled lane differed from the R3 pattern. Bytes on disabled lanes are not compared. `mismatch` keeps its value through write bursts.
- R11: `busy` is high from the cycle after an accepted `go` until the burst ends, and is low in the `done` cycle. `go` is ignored while `busy` is high. After reset, `busy`, `done` and `mismatch` are low.
- R12: `mc_refresh_ack` has no effect on any output.
- R13: `mc_be` carries the command's byte enables, one bit per byte lane, bit j for lane j, for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Command strobe, accepted when idle |
| go_read | input | 1 | 1 selects a read burst, 0 a write burst |
| go_cs | input | CS_W | Chip-select of the first beat |
| go_row | input | ROW_W | Row of the first beat |
| go_bank | input | BANK_W | Bank of the first beat |
| go_col | input | COL_W | Column of the first beat |
| go_size | input | SIZE_W | Requested burst length in beats |
| go_be | input | NBYTE | Byte-lane enables |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle burst completion pulse |
| mismatch | output | 1 | Read-back compare result |
| mc_init_ok | input | 1 | Controller initialisation complete |
| mc_ready | input | 1 | Controller accepts the presented beat |
| mc_refresh_ack | input | 1 | Refresh acknowledge, ignored |
| mc_rdata | input | LD_W | Read data beat |
| mc_rvalid | input | 1 | Read data valid strobe |
| mc_addr | output | ADDR_W | Combined beat address |
| mc_wr_req | output | 1 | Write request |
| mc_rd_req | output | 1 | Read request |
| mc_burst_start | output | 1 | First-beat marker |
| mc_size | output | SIZE_W | Burst length in beats |
| mc_be | output | NBYTE | Byte enables |
| mc_wdata | output | LD_W | Write data beat |

## Verification
The assertions rely on three things about the controller. `mc_init_ok` never falls once it has risen. `mc_rvalid` beats arrive only after an accepted read, and there are exactly as many as the size it carried. `mc_ready` may be low for any number of cycles. The bench keeps to these by raising `mc_init_ok` once and leaving it high. Its controller model returns read beats only from its pending-read count, and it sets ready and read gaps from a shift register under three stall densities. It also toggles the refresh acknowledge and the read data on idle cycles, so that neither can affect the outputs.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_WR   = 3'd2,
    ST_RCMD = 3'd3,
    ST_RDAT = 3'd4
  } lbm_state_e;

endpackage

// File: rtl/lbm_beat_ctr.sv
module lbm_beat_ctr #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = clr ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign last = (cnt == limit - CNT_W'(1));

endmodule

// File: rtl/lbm_pattern.sv
module lbm_pattern #(
  parameter int ADDR_W = 10,
  parameter int BEAT_W = 3,
  parameter int NBYTE  = 2
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [BEAT_W-1:0]  beat,
  output logic [8*NBYTE-1:0] data
);

  for (genvar j = 0; j < NBYTE; j++) begin : g_lane
    assign data[8*j +: 8] = 8'(32'(base) + 32'(beat) * 32'(NBYTE) + 32'(j));
  end

endmodule

// File: rtl/lbm_rd_check.sv
module lbm_rd_check #(
  parameter int NBYTE = 2,
  localparam int LD_W = 8 * NBYTE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic             fin,
  input  logic [LD_W-1:0]  rdata,
  input  logic [LD_W-1:0]  expect_data,
  input  logic [NBYTE-1:0] be,
  output logic             mismatch
);

  logic [LD_W-1:0] lane_mask;
  logic            beat_bad;
  logic            err_q;
  logic            err_d;
  logic            err_en;

  for (genvar j = 0; j < NBYTE; j++) begin : g_mask
    assign lane_mask[8*j +: 8] = {8{be[j]}};
  end

  always_comb begin
    beat_bad = sample & (|((rdata ^ expect_data) & lane_mask));
    err_en   = clr | beat_bad;
    err_d    = ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mismatch <= 1'b0;
    else if (fin) mismatch <= err_q | beat_bad;
  end

endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SIZE_W   = 3,
  parameter int NBYTE    = 2,
  parameter int MAX_SIZE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_read,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [SIZE_W-1:0] go_size,
  input  logic [NBYTE-1:0]  go_be,
  input  logic              init_ok,
  input  logic              ready,
  input  logic              rvalid,
  input  logic              beat_last,
  output logic              wr_req,
  output logic              rd_req,
  output logic              burst_start,
  output logic              busy,
  output logic              cnt_clr,
  output logic              cnt_inc,
  output logic              rd_sample,
  output logic              fin_rd,
  output logic              done,
  output logic [ADDR_W-1:0] addr,
  output logic [SIZE_W-1:0] size,
  output logic [NBYTE-1:0]  be
);

  localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(MAX_SIZE);
  localparam logic [SIZE_W-1:0] SZ_MIN = SIZE_W'(1);

  lbm_state_e        st_q, st_d;
  logic              rd_q;
  logic              started_q, started_d;
  logic              fin;
  logic              cmd_ld;
  logic [SIZE_W-1:0] size_eff;

  always_comb begin
    if (go_size == '0)        size_eff = SZ_MIN;
    else if (go_size > SZ_MAX) size_eff = SZ_MAX;
    else                      size_eff = go_size;
  end

  always_comb begin
    st_d = st_q;
    fin  = 1'b0;
    case (st_q)
      ST_IDLE: if (go) st_d = ST_ARM;
      ST_ARM:  if (init_ok) st_d = rd_q ? ST_RCMD : ST_WR;
      ST_WR: begin
        if (ready && beat_last) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end
      end
      ST_RCMD: if (ready) st_d = ST_RDAT;
      ST_RDAT: begin
        if (rvalid && beat_last) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    wr_req      = (st_q == ST_WR);
    rd_req      = (st_q == ST_RCMD);
    started_d   = wr_req | rd_req;
    burst_start = (wr_req | rd_req) & ~started_q;
    busy        = (st_q != ST_IDLE);
    cmd_ld      = (st_q == ST_IDLE) & go;
    cnt_clr     = (st_q == ST_ARM);
    rd_sample   = (st_q == ST_RDAT) & rvalid;
    cnt_inc     = (wr_req & ready) | rd_sample;
    fin_rd      = fin & rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      started_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      st_q      <= st_d;
      started_q <= started_d;
      done      <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      addr <= '0;
      size <= SZ_MIN;
      be   <= '0;
    end else if (cmd_ld) begin
      rd_q <= go_read;
      addr <= go_addr;
      size <= size_eff;
      be   <= go_be;
    end
  end

endmodule

// File: rtl/mc_burst_master.sv
module mc_burst_master #(
  parameter int CS_W     = 1,
  parameter int ROW_W    = 4,
  parameter int BANK_W   = 2,
  parameter int COL_W    = 3,
  parameter int DEV_DQ_W = 8,
  parameter int MAX_SIZE = 4,
  localparam int LD_W    = 2 * DEV_DQ_W,
  localparam int NBYTE   = LD_W / 8,
  localparam int ADDR_W  = CS_W + ROW_W + BANK_W + COL_W,
  localparam int SIZE_W  = $clog2(MAX_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_read,
  input  logic [CS_W-1:0]   go_cs,
  input  logic [ROW_W-1:0]  go_row,
  input  logic [BANK_W-1:0] go_bank,
  input  logic [COL_W-1:0]  go_col,
  input  logic [SIZE_W-1:0] go_size,
  input  logic [NBYTE-1:0]  go_be,
  output logic              busy,
  output logic              done,
  output logic              mismatch,
  input  logic              mc_init_ok,
  input  logic              mc_ready,
  input  logic              mc_refresh_ack,
  input  logic [LD_W-1:0]   mc_rdata,
  input  logic              mc_rvalid,
  output logic [ADDR_W-1:0] mc_addr,
  output logic              mc_wr_req,
  output logic              mc_rd_req,
  output logic              mc_burst_start,
  output logic [SIZE_W-1:0] mc_size,
  output logic [NBYTE-1:0]  mc_be,
  output logic [LD_W-1:0]   mc_wdata
);

  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic              refresh_unused;
  logic [ADDR_W-1:0] go_addr;
  logic              cnt_clr, cnt_inc, rd_sample, fin_rd;
  logic [SIZE_W-1:0] beat;
  logic              beat_last;
  logic [LD_W-1:0]   pat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  assign refresh_unused = mc_refresh_ack;
  assign go_addr        = {go_cs, go_row, go_bank, go_col};

  lbm_seq #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .NBYTE(NBYTE), .MAX_SIZE(MAX_SIZE)
  ) u_seq (
    .clk(clk), .rst_n(rst_q_n),
    .go(go), .go_read(go_read), .go_addr(go_addr), .go_size(go_size), .go_be(go_be),
    .init_ok(mc_init_ok), .ready(mc_ready), .rvalid(mc_rvalid), .beat_last(beat_last),
    .wr_req(mc_wr_req), .rd_req(mc_rd_req), .burst_start(mc_burst_start), .busy(busy),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .rd_sample(rd_sample), .fin_rd(fin_rd),
    .done(done), .addr(mc_addr), .size(mc_size), .be(mc_be)
  );

  lbm_beat_ctr #(.CNT_W(SIZE_W)) u_ctr (
    .clk(clk), .rst_n(rst_q_n), .clr(cnt_clr), .inc(cnt_inc),
    .limit(mc_size), .cnt(beat), .last(beat_last)
  );

  lbm_pattern #(.ADDR_W(ADDR_W), .BEAT_W(SIZE_W), .NBYTE(NBYTE)) u_pat (
    .base(mc_addr), .beat(beat), .data(pat_data)
  );

  assign mc_wdata = pat_data;

  lbm_rd_check #(.NBYTE(NBYTE)) u_chk (
    .clk(clk), .rst_n(rst_q_n), .clr(cnt_clr), .sample(rd_sample), .fin(fin_rd),
    .rdata(mc_rdata), .expect_data(pat_data), .be(mc_be), .mismatch(mismatch)
  );

endmodule

// File: rtl/lbm_sva.sv
module lbm_sva #(
  parameter int ADDR_W   = 10,
  parameter int LD_W     = 16,
  parameter int NBYTE    = 2,
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_ok,
  input logic              ready,
  input logic              wr_req,
  input logic              rd_req,
  input logic              burst_start,
  input logic [ADDR_W-1:0] addr,
  input logic [LD_W-1:0]   wdata,
  input logic [NBYTE-1:0]  be,
  input logic [SIZE_W-1:0] size,
  input logic              done,
  input logic              busy
);

  AST_NO_REQ_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ok |-> !(wr_req || rd_req)); // R1

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_req || rd_req) && !ready) |=> ($stable(addr) && $stable(wdata) && $stable(be)
      && $stable(size) && $stable(wr_req) && $stable(rd_req))); // R5

  AST_START_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (wr_req || rd_req)); // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !burst_start); // R4

  AST_SIZE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |-> (size >= SIZE_W'(1) && size <= SIZE_W'(MAX_SIZE))); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

endmodule

bind mc_burst_master lbm_sva #(
  .ADDR_W(ADDR_W), .LD_W(LD_W), .NBYTE(NBYTE), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)
) u_sva (
  .clk(clk), .rst_n(rst_n), .init_ok(mc_init_ok), .ready(mc_ready),
  .wr_req(mc_wr_req), .rd_req(mc_rd_req), .burst_start(mc_burst_start),
  .addr(mc_addr), .wdata(mc_wdata), .be(mc_be), .size(mc_size),
  .done(done), .busy(busy)
);

// File: tb/sim_mc_burst_master.sv
`timescale 1ns/1ps
module sim_mc_burst_master;

  logic clk = 1'b0;
  logic rst_n;
  logic go, go_read;
  logic [0:0] go_cs;
  logic [3:0] go_row;
  logic [1:0] go_bank;
  logic [2:0] go_col;
  logic [2:0] go_size;
  logic [1:0] go_be;
  logic busy, done, mismatch;
  logic mc_init_ok;
  logic mc_ready = 1'b0;
  logic mc_refresh_ack = 1'b0;
  logic [15:0] mc_rdata = 16'h0;
  logic mc_rvalid = 1'b0;
  logic [9:0] mc_addr;
  logic mc_wr_req, mc_rd_req, mc_burst_start;
  logic [2:0] mc_size;
  logic [1:0] mc_be;
  logic [15:0] mc_wdata;

  always #4 clk = ~clk;

  mc_burst_master u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .go_read(go_read), .go_cs(go_cs), .go_row(go_row),
    .go_bank(go_bank), .go_col(go_col), .go_size(go_size), .go_be(go_be),
    .busy(busy), .done(done), .mismatch(mismatch),
    .mc_init_ok(mc_init_ok), .mc_ready(mc_ready), .mc_refresh_ack(mc_refresh_ack),
    .mc_rdata(mc_rdata), .mc_rvalid(mc_rvalid), .mc_addr(mc_addr), .mc_wr_req(mc_wr_req),
    .mc_rd_req(mc_rd_req), .mc_burst_start(mc_burst_start), .mc_size(mc_size),
    .mc_be(mc_be), .mc_wdata(mc_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mon_on = 0;
  int mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] mem [0:1023];

  int e_addr, e_n, e_be;
  bit e_read;
  int beats, bs_cnt, rd_acc, rd_left, rd_k, rd_delay;
  bit e_mm, mm_hold, exp_done;
  bit p_req, p_ready;
  logic [9:0] p_addr; logic [15:0] p_wdata; logic [1:0] p_be; logic [2:0] p_size;
  logic p_wr, p_rd;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int k);
    logic [15:0] r;
    for (int j = 0; j < 2; j++) r[8*j +: 8] = 8'((a + 2*k + j) & 255);
    return r;
  endfunction

  function automatic logic [15:0] lanes(input int b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic int clampsz(input int s);
    if (s == 0) return 1;
    if (s > 4) return 4;
    return s;
  endfunction

  function automatic int cmb(input int cs, input int row, input int bank, input int col);
    return (cs << 9) | (row << 5) | (bank << 3) | col;
  endfunction

  // controller model and port monitor, all at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mc_refresh_ack = lfsr[7];
    if (mon_on) begin
      bit req;
      req = mc_wr_req | mc_rd_req;
      if (!(mc_wr_req && mc_rd_req) == 1'b0) chk(0, "R8 both requests", 3, 1);
      if (!mc_init_ok) chk(!req, "R1 request before init", req, 0);
      if (p_req && !p_ready) begin
        chk(mc_addr == p_addr && mc_wdata == p_wdata && mc_be == p_be && mc_size == p_size
            && mc_wr_req == p_wr && mc_rd_req == p_rd, "R5 stall hold", mc_wdata, p_wdata);
      end
      if (rd_left > 0 || (e_read && rd_acc == 1 && !exp_done && !done))
        if (rd_acc == 1) chk(!req, "R7 request during read data", req, 0);
      if (mc_burst_start) begin
        bs_cnt++;
        chk(!p_req, "R4 start not on first cycle", p_req, 0);
      end
      if (done || exp_done) begin
        chk(done == exp_done, "R9 done timing", done, exp_done);
        if (done) begin
          chk(bs_cnt == 1, "R4 start count", bs_cnt, 1);
          chk(!busy, "R11 busy at done", busy, 0);
          if (e_read) begin
            chk(rd_acc == 1, "R7 read requests", rd_acc, 1);
            chk(mismatch == e_mm, "R10 read compare", mismatch, e_mm);
            mm_hold = e_mm;
          end else begin
            chk(beats == e_n, "R6 write beats", beats, e_n);
            chk(mismatch == mm_hold, "R10 held over write", mismatch, mm_hold);
          end
        end
        exp_done = 0;
      end
      // read data return
      mc_rvalid = 1'b0;
      mc_rdata = lfsr;
      if (rd_left > 0) begin
        if (rd_delay > 0) rd_delay--;
        else if (mode == 0 || lfsr[5]) begin
          logic [15:0] d;
          d = mem[(e_addr + rd_k) % 1024];
          mc_rdata = d;
          mc_rvalid = 1'b1;
          if (((d ^ pat(e_addr, rd_k)) & lanes(e_be)) != 16'h0) e_mm = 1;
          rd_k++;
          rd_left--;
          if (rd_left == 0) exp_done = 1;
        end
      end
      case (mode)
        0: mc_ready = 1'b1;
        1: mc_ready = lfsr[0] | lfsr[3];
        default: mc_ready = lfsr[1] & lfsr[2];
      endcase
      if (req && mc_ready) begin
        chk(busy, "R11 busy during burst", busy, 1);
        chk(mc_addr == 10'(e_addr), "R2 address", mc_addr, e_addr);
        chk(mc_size == 3'(e_n), "R6 size field", mc_size, e_n);
        chk(mc_be == 2'(e_be), "R13 byte enables", mc_be, e_be);
        if (mc_wr_req) begin
          chk(mc_wdata == pat(e_addr, beats), "R3 write data", mc_wdata, pat(e_addr, beats));
          for (int j = 0; j < 2; j++)
            if (e_be[j]) mem[(e_addr + beats) % 1024][8*j +: 8] = mc_wdata[8*j +: 8];
          beats++;
          if (beats == e_n) exp_done = 1;
        end else begin
          rd_acc++;
          rd_left = e_n;
          rd_k = 0;
          rd_delay = 2;
        end
      end
      p_req = req; p_ready = mc_ready; p_addr = mc_addr; p_wdata = mc_wdata;
      p_be = mc_be; p_size = mc_size; p_wr = mc_wr_req; p_rd = mc_rd_req;
    end
  end

  task automatic issue(input bit rd, input int cs, input int row, input int bank,
                       input int col, input int sz, input int b);
    e_addr = cmb(cs, row, bank, col); e_n = clampsz(sz); e_be = b; e_read = rd;
    beats = 0; bs_cnt = 0; rd_acc = 0; e_mm = 0;
    go_read = rd; go_cs = 1'(cs); go_row = 4'(row); go_bank = 2'(bank);
    go_col = 3'(col); go_size = 3'(sz); go_be = 2'(b); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_done(input bit poke);
    int n;
    n = 0;
    while (!done && n < 2000) begin
      if (poke && n == 3) begin
        go_read = ~e_read; go_cs = ~go_cs; go_row = go_row + 4'd5; go_size = 3'd2;
        go_be = ~go_be; go = 1'b1;
      end else go = 1'b0;
      @(negedge clk);
      n++;
    end
    go = 1'b0;
    if (n >= 2000) chk(0, "R9 done never came", 0, 1);
    @(negedge clk);
  endtask

  task automatic op(input bit rd, input int cs, input int row, input int bank,
                    input int col, input int sz, input int b, input bit poke);
    issue(rd, cs, row, bank, col, sz, b);
    wait_done(poke);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'hA5A5 ^ 16'(i * 37);
    go = 0; go_read = 0; go_cs = 0; go_row = 0; go_bank = 0; go_col = 0; go_size = 0; go_be = 0;
    mc_init_ok = 1'b0;
    exp_done = 0; mm_hold = 0; p_req = 0; p_ready = 0; rd_left = 0; rd_acc = 0; e_read = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mc_wr_req && !mc_rd_req, "R1 requests after reset", mc_wr_req, 0);
    chk(!busy && !done && !mismatch, "R11 reset state", {busy, done, mismatch}, 0);
    mon_on = 1;
    // command before init: must wait
    mode = 1;
    issue(0, 1, 9, 2, 5, 4, 3);
    repeat (20) @(negedge clk);
    chk(busy, "R11 busy while waiting for init", busy, 1);
    chk(!mc_wr_req && !mc_rd_req, "R1 held until init", mc_wr_req, 0);
    mc_init_ok = 1'b1;
    wait_done(0);
    op(1, 1, 9, 2, 5, 4, 3, 0);
    // sweep of modes, sizes, lanes
    for (int m = 0; m < 3; m++) begin
      mode = m;
      for (int sz = 0; sz < 8; sz++) begin
        for (int b = 1; b < 4; b++) begin
          int cs, row, bank, col;
          cs = sz & 1; row = (sz * 3 + b + m) & 15; bank = b & 3; col = (sz + m) & 7;
          op(0, cs, row, bank, col, sz, b, 0);
          op(1, cs, row, bank, col, sz, b, 0);
        end
      end
    end
    // go while busy is ignored
    mode = 2;
    op(0, 0, 3, 1, 6, 4, 3, 1);
    repeat (5) @(negedge clk);
    chk(!busy && !mc_wr_req && !mc_rd_req, "R11 no extra command", busy, 0);
    op(1, 0, 3, 1, 6, 4, 3, 1);
    // refresh acknowledge while idle
    repeat (12) @(negedge clk);
    chk(!busy && !mc_wr_req && !mc_rd_req && !done, "R12 refresh ignored", busy, 0);
    // corrupted read-back
    mode = 1;
    op(0, 1, 12, 0, 2, 4, 3, 0);
    mem[(cmb(1, 12, 0, 2) + 2) % 1024][7:0] = ~mem[(cmb(1, 12, 0, 2) + 2) % 1024][7:0];
    op(1, 1, 12, 0, 2, 4, 3, 0);
    chk(mismatch == 1'b1, "R10 corrupted lane reported", mismatch, 1);
    op(0, 0, 1, 1, 1, 2, 3, 0);
    chk(mismatch == 1'b1, "R10 kept across write", mismatch, 1);
    op(1, 1, 12, 0, 2, 4, 2, 0);
    chk(mismatch == 1'b0, "R10 masked lane ignored", mismatch, 0);
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule